// File: doc/BRIEF.md
# Multi-Mode Timer Counter with Buffered Reload

This block is a timer counter that moves one step on each cycle where a count tick arrives while the block is enabled. It has two counting schemes. In the falling scheme the count goes down to zero and then reloads from a programmable period value. In the symmetric scheme the count climbs from zero to the period value and then descends back to zero, over and over. A hardware-maintained direction bit shows which way the count is moving.

The period value can be changed at once, or it can be held back in a buffer copy that only takes the written value when an update event occurs. Update events come from the turning points of the count and from a software trigger. Each event gives a one-clock pulse and sets a sticky flag. An inhibit input suppresses both the event and the buffer refresh. The prescaler that produces the tick is outside the block.

Top module: `updown_reload_timer`

## Requirements
- R1: While reset is held and just after it, the count is 0, the direction bit is 0 (rising), the update pulse and the flag are 0, and both the written period register and its buffer copy hold all ones. A first falling-mode step from count 0 after reset therefore loads 16'hFFFF.
- R2: The count changes only on a cycle where both the enable input and the tick input are 1, or on a software trigger. Otherwise it holds its value.
- R3: With the mode input at 0 (falling scheme), each step lowers the count by 1. A step taken at count 0 loads the active period value and raises an update. The update pulse is high for exactly the one clock in which the reloaded count first appears.
- R4: With the buffer input at 0, a period write is used from the next clock onward, including by a reload that occurs at that next step. A write does not change the current count.
- R5: With the buffer input at 1, reloads use the buffer copy. The buffer copy takes the value held in the written period register (before any same-cycle write) only on a clock that carries an update event.
- R6: With the mode input at 1 (symmetric scheme), the count rises from 0 to the period value and then falls back to 0, repeating. The direction bit reads 0 while rising and 1 while falling. In the falling scheme the direction bit reads 1 from the clock after reset release.
- R7: In the symmetric scheme, a step taken at period-1 while rising raises an update (overflow), and a step taken at 1 while falling raises an update (underflow). No other counting step raises one. With a period of 0 the count stays at 0.
- R8: A software trigger pulse sets the count to 0 on the next clock and produces an update pulse, whatever the direction or tick on that cycle. In the symmetric scheme it also sets the direction bit to 0.
- R9: The flag is set together with every update pulse and stays at 1 until a one-cycle clear input. When a set and a clear fall on the same clock, the set wins.
- R10: While the inhibit input is 1, no update pulse is produced, the flag is not set and the buffer copy keeps its old value. Counting and reloading carry on as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Counting enable |
| tick_i | input | 1 | Prescaled count tick |
| mode_i | input | 1 | 0 = falling scheme, 1 = symmetric up/down scheme |
| period_wr_i | input | 1 | Period write strobe |
| period_data_i | input | CNT_W | Period value to write |
| buffered_i | input | 1 | 1 = reloads use the buffer copy |
| sw_update_i | input | 1 | Software update trigger, one cycle |
| upd_inhibit_i | input | 1 | Suppresses update events and buffer refresh |
| flag_clr_i | input | 1 | Clears the sticky flag, one cycle |
| count_o | output | CNT_W | Current count |
| dir_o | output | 1 | 0 = rising, 1 = falling |
| update_o | output | 1 | One-clock update event pulse |
| flag_o | output | 1 | Sticky update flag |

## Verification
On every cycle the embedded assertions check these local rules: the count holds without a step, a falling-scheme step lowers it by one, and a software trigger zeroes it. They also check that an inhibited cycle gives no pulse, that the flag keeps its value and follows each pulse, that the buffer copy moves only on update events, and that an unbuffered write appears at the next clock. Only the bench scenarios can show the longer sequences. These are the full rise-and-fall trajectory with its turning points, the exact cycle of each reload and event, and the fact that a buffered write is delayed by one whole period. They also cover the buffer keeping its old value across an inhibited turning point.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Counting scheme selected by mode_i
    typedef enum logic {
        SCHEME_FALL = 1'b0,
        SCHEME_SYM  = 1'b1
    } scheme_e;

    // Turning-point events produced by the counting core
    typedef struct packed {
        logic ovf;
        logic unf;
    } turn_evt_t;

endpackage

// File: rtl/tmr_period_regs.sv
module tmr_period_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] data_i,
    input  logic             buffered_i,
    input  logic             upd_evt_i,
    output logic [CNT_W-1:0] period_o
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [CNT_W-1:0] written;
        logic [CNT_W-1:0] buffer;
    } per_state_t;

    per_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            state_d.written = data_i;
        end
        // the buffer copies the value registered before this edge
        if (upd_evt_i) begin
            state_d.buffer = state_q.written;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{written: ALL_ONES, buffer: ALL_ONES};
        end else begin
            state_q <= state_d;
        end
    end

    assign period_o = buffered_i ? state_q.buffer : state_q.written;

    // R5 R10
    buffer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_evt_i |=> $stable(state_q.buffer));

    // R4
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !buffered_i) |=> (buffered_i || period_o == $past(data_i)));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  scheme_e          scheme_i,
    input  logic             sw_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_o,
    output turn_evt_t        evt_o
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
    } core_state_t;

    core_state_t state_d, state_q;
    turn_evt_t   evt_d;

    logic [CNT_W-1:0] top_m1;
    logic             at_top_m1;
    logic             at_or_above_top;
    logic             at_one;
    logic             at_zero;

    assign top_m1          = period_i - ONE;
    assign at_top_m1       = (state_q.cnt == top_m1);
    assign at_or_above_top = (state_q.cnt >= period_i);
    assign at_one          = (state_q.cnt == ONE);
    assign at_zero         = (state_q.cnt == ZERO);

    always_comb begin
        state_d = state_q;
        evt_d   = '0;
        // the falling scheme always reports a falling direction
        if (scheme_i == SCHEME_FALL) begin
            state_d.dir = 1'b1;
        end

        if (sw_i) begin
            state_d.cnt = ZERO;
            state_d.dir = (scheme_i == SCHEME_FALL);
        end else if (step_i) begin
            unique case (scheme_i)
                SCHEME_FALL: begin
                    if (at_zero) begin
                        state_d.cnt = period_i;
                        evt_d.unf   = 1'b1;
                    end else begin
                        state_d.cnt = state_q.cnt - ONE;
                    end
                end
                SCHEME_SYM: begin
                    if (period_i == ZERO) begin
                        state_d.cnt = ZERO;
                        state_d.dir = 1'b0;
                    end else if (!state_q.dir) begin
                        if (at_top_m1) begin
                            state_d.cnt = state_q.cnt + ONE;
                            state_d.dir = 1'b1;
                            evt_d.ovf   = 1'b1;
                        end else if (at_or_above_top) begin
                            // period lowered below count: turn without an event
                            state_d.cnt = state_q.cnt - ONE;
                            state_d.dir = 1'b1;
                        end else begin
                            state_d.cnt = state_q.cnt + ONE;
                        end
                    end else begin
                        if (at_one) begin
                            state_d.cnt = ZERO;
                            state_d.dir = 1'b0;
                            evt_d.unf   = 1'b1;
                        end else if (at_zero) begin
                            state_d.dir = 1'b0;
                        end else begin
                            state_d.cnt = state_q.cnt - ONE;
                        end
                    end
                end
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{cnt: ZERO, dir: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = state_q.cnt;
    assign dir_o   = state_q.dir;
    assign evt_o   = evt_d;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !sw_i) |=> $stable(count_o));

    // R3
    fall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !sw_i && scheme_i == SCHEME_FALL && count_o != ZERO)
        |=> count_o == $past(count_o) - ONE);

    // R8
    sw_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_i |=> count_o == ZERO);

endmodule

// File: rtl/tmr_update_ctrl.sv
module tmr_update_ctrl
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  turn_evt_t evt_i,
    input  logic      sw_i,
    input  logic      inhibit_i,
    input  logic      clr_i,
    output logic      upd_evt_o,
    output logic      update_o,
    output logic      flag_o
);

    typedef struct packed {
        logic pulse;
        logic flag;
    } upd_state_t;

    upd_state_t state_d, state_q;
    logic       raw_evt;

    assign raw_evt   = evt_i.ovf | evt_i.unf | sw_i;
    assign upd_evt_o = raw_evt & ~inhibit_i;

    always_comb begin
        state_d       = state_q;
        state_d.pulse = upd_evt_o;
        if (clr_i) begin
            state_d.flag = 1'b0;
        end
        // a set on the same clock overrides the clear
        if (upd_evt_o) begin
            state_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign update_o = state_q.pulse;
    assign flag_o   = state_q.flag;

    // R10
    no_update_when_inhibited_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> !update_o);

    // R9
    flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> flag_o);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/updown_reload_timer.sv
module updown_reload_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             tick_i,
    input  logic             mode_i,
    input  logic             period_wr_i,
    input  logic [CNT_W-1:0] period_data_i,
    input  logic             buffered_i,
    input  logic             sw_update_i,
    input  logic             upd_inhibit_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_o,
    output logic             update_o,
    output logic             flag_o
);

    logic             step;
    logic             upd_evt;
    logic [CNT_W-1:0] period;
    turn_evt_t        turn_evt;
    scheme_e          scheme;

    assign step   = enable_i & tick_i;
    assign scheme = scheme_e'(mode_i);

    tmr_period_regs #(.CNT_W(CNT_W)) u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (period_wr_i),
        .data_i     (period_data_i),
        .buffered_i (buffered_i),
        .upd_evt_i  (upd_evt),
        .period_o   (period)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .scheme_i (scheme),
        .sw_i     (sw_update_i),
        .period_i (period),
        .count_o  (count_o),
        .dir_o    (dir_o),
        .evt_o    (turn_evt)
    );

    tmr_update_ctrl u_upd (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (turn_evt),
        .sw_i      (sw_update_i),
        .inhibit_i (upd_inhibit_i),
        .clr_i     (flag_clr_i),
        .upd_evt_o (upd_evt),
        .update_o  (update_o),
        .flag_o    (flag_o)
    );

endmodule

// File: tb/updown_reload_timer_tb.sv
module updown_reload_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, tick = 1'b0, mode = 1'b0, wr = 1'b0, buf_en = 1'b0;
    logic        sw = 1'b0, inh = 1'b0, clr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] count;
    logic        dir, upd, flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] cnt;
        logic        dir;
        logic        upd;
        logic        flag;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    updown_reload_timer #(.CNT_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable_i(en), .tick_i(tick), .mode_i(mode),
        .period_wr_i(wr), .period_data_i(wdata), .buffered_i(buf_en),
        .sw_update_i(sw), .upd_inhibit_i(inh), .flag_clr_i(clr),
        .count_o(count), .dir_o(dir), .update_o(upd), .flag_o(flag)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: inputs already set at this negedge; expectation is for after next posedge
    task automatic cyc(input logic [15:0] c, input logic d, input logic u,
                       input logic f, input string tag);
        exp_t e;
        e.cnt = c; e.dir = d; e.upd = u; e.flag = f; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " count"}, count, e.cnt);
                check({e.tag, " dir"}, {15'd0, dir}, {15'd0, e.dir});
                check({e.tag, " update"}, {15'd0, upd}, {15'd0, e.upd});
                check({e.tag, " flag"}, {15'd0, flag}, {15'd0, e.flag});
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset count", count, 16'h0);
        check("R1 reset dir", {15'd0, dir}, 16'h0);
        check("R1 reset update", {15'd0, upd}, 16'h0);
        check("R1 reset flag", {15'd0, flag}, 16'h0);
        rst_n = 1'b1;

        // falling scheme, first reload from all-ones period
        en = 1; tick = 1; mode = 0; buf_en = 0;
        cyc(16'hFFFF, 1, 1, 1, "R1 R3 first reload");
        cyc(16'hFFFE, 1, 0, 1, "R3 decrement");
        en = 0;
        cyc(16'hFFFE, 1, 0, 1, "R2 enable low");
        en = 1; tick = 0;
        cyc(16'hFFFE, 1, 0, 1, "R2 no tick");
        clr = 1;
        cyc(16'hFFFE, 1, 0, 0, "R9 clear");
        clr = 0; wr = 1; wdata = 16'd3;
        cyc(16'hFFFE, 1, 0, 0, "R4 write keeps count");
        wr = 0; sw = 1;
        cyc(16'h0000, 1, 1, 1, "R8 sw trigger falling");
        sw = 0; tick = 1; clr = 1;
        cyc(16'd3, 1, 1, 1, "R4 R9 reload and set beats clear");
        clr = 0;
        cyc(16'd2, 1, 0, 1, "R3 count");
        clr = 1;
        cyc(16'd1, 1, 0, 0, "R3 count");
        clr = 0;
        cyc(16'd0, 1, 0, 0, "R3 count");
        tick = 0; wr = 1; wdata = 16'd5;
        cyc(16'd0, 1, 0, 0, "R4 write at zero");
        wr = 0; tick = 1;
        cyc(16'd5, 1, 1, 1, "R4 immediate period");

        // buffered period: buffer now holds 5
        buf_en = 1; tick = 0; wr = 1; wdata = 16'd2; clr = 1;
        cyc(16'd5, 1, 0, 0, "R5 buffered write");
        wr = 0; clr = 0; tick = 1;
        for (int k = 4; k >= 0; k--) cyc(16'(k), 1, 0, 0, "R5 count");
        cyc(16'd5, 1, 1, 1, "R5 old buffer used");
        for (int k = 4; k >= 0; k--) cyc(16'(k), 1, 0, 1, "R5 count");
        cyc(16'd2, 1, 1, 1, "R5 new buffer used");

        // inhibit: buffer stays 2 although 7 is written
        inh = 1; wr = 1; wdata = 16'd7; clr = 1; tick = 0;
        cyc(16'd2, 1, 0, 0, "R10 setup");
        wr = 0; clr = 0; tick = 1;
        cyc(16'd1, 1, 0, 0, "R10 count");
        cyc(16'd0, 1, 0, 0, "R10 count");
        cyc(16'd2, 1, 0, 0, "R10 reload without event");
        inh = 0;
        cyc(16'd1, 1, 0, 0, "R10 count");
        cyc(16'd0, 1, 0, 0, "R10 count");
        cyc(16'd2, 1, 1, 1, "R10 buffer kept old value");
        cyc(16'd1, 1, 0, 1, "R5 count");
        cyc(16'd0, 1, 0, 1, "R5 count");
        cyc(16'd7, 1, 1, 1, "R5 buffer refreshed");

        // symmetric scheme with period 3
        mode = 1; buf_en = 0; wr = 1; wdata = 16'd3; sw = 1; tick = 0;
        cyc(16'd0, 0, 1, 1, "R8 sw trigger enters rising");
        wr = 0; sw = 0; clr = 1; tick = 1;
        cyc(16'd1, 0, 0, 0, "R6 rising");
        clr = 0;
        cyc(16'd2, 0, 0, 0, "R6 rising");
        cyc(16'd3, 1, 1, 1, "R7 overflow at period-1");
        cyc(16'd2, 1, 0, 1, "R6 falling");
        cyc(16'd1, 1, 0, 1, "R6 falling");
        cyc(16'd0, 0, 1, 1, "R7 underflow at 1");
        cyc(16'd1, 0, 0, 1, "R6 rising again");
        cyc(16'd2, 0, 0, 1, "R6 rising");
        cyc(16'd3, 1, 1, 1, "R7 overflow");
        cyc(16'd2, 1, 0, 1, "R6 falling");
        sw = 1;
        cyc(16'd0, 0, 1, 1, "R8 sw trigger while falling");
        sw = 0;
        cyc(16'd1, 0, 0, 1, "R8 rising after trigger");

        // zero period in symmetric scheme
        wr = 1; wdata = 16'd0; tick = 0; clr = 1;
        cyc(16'd1, 0, 0, 0, "R7 write zero period");
        wr = 0; clr = 0; tick = 1;
        cyc(16'd0, 0, 0, 0, "R7 zero period");
        cyc(16'd0, 0, 0, 0, "R7 zero period holds");

        while (sb.size() > 0) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule